// File: doc/BRIEF.md
# Card Data FIFO with Watermark DMA Requests

This block is the data buffer of a memory-card host controller. A 32-word by 16-bit circular FIFO sits between the processor register port and the card-side byte engine. In the receive direction the card engine pushes words and the processor (or a DMA channel) reads them from the data register. In the transmit direction the processor writes the data register and the card engine pops words. Storage is a head index plus an occupancy count, and both wrap modulo the depth.

Two programmable watermarks watch the occupancy. A high mark serves the receive direction and a low mark serves the transmit direction. When a watermark condition holds, the block either raises that direction's DMA request or sets that direction's status flag. A per-direction DMA enable in the buffer-configuration register makes the choice. The block also holds a 16-bit write-one-to-clear status register. Its other bits are set by event pulses from neighbouring logic. An interrupt-enable mask and a single interrupt line complete it.

Register selects on `reg_addr` are: 0 = data, 1 = buffer configuration, 2 = status, 3 = interrupt mask. On `xfer_dir`, 1 means receive (card to processor) and 0 means transmit.

Top module: `card_fifo_wm`

## Requirements
- R1: After reset, the configuration register reads 0x1F00 (high mark 31, low mark 0, both DMA enables off). Status, mask, level, interrupt and both DMA requests are 0. The data register reads 0.
- R2: Words leave the FIFO in the order they were pushed, across index wrap. A push comes from a processor write to select 0 or from `card_push`. A pop comes from a processor read of select 0 or from `card_pop`. `fifo_level` gives the occupancy, and `card_rdata` and a select-0 read both show the head word.
- R3: A push while the FIFO holds 32 words is dropped. The level stays 32 and the stored words are unchanged.
- R4: A pop while the FIFO is empty returns the head word and changes neither the pointers nor the level.
- R5: Let the FIFO be live when `xfer_active` is 1 or the level is non-zero. With `xfer_dir` = 1, a live FIFO and level above the high mark, `dma_rx_req` is 1 if receive DMA is enabled; otherwise status bit 10 is 1. In every other case both are 0.
- R6: With `xfer_dir` = 0, a live FIFO and level below the low mark, `dma_tx_req` is 1 if transmit DMA is enabled; otherwise status bit 11 is 1. In every other case both are 0.
- R7: When `xfer_active` is 0 and the FIFO is empty, status bits 10 and 11 and both DMA requests are 0.
- R8: The configuration register holds receive DMA enable in bit 15, the high mark in bits 12:8, transmit DMA enable in bit 7 and the low mark in bits 4:0. Other bits read 0. Setting a DMA enable clears its direction's status bit.
- R9: Writing select 2 clears every status bit written as 1 and leaves the others. A 1 on `evt_set` sets the matching bit and wins over a clear in the same cycle. Bits 10 and 11 follow only the watermark rules, so `evt_set` and clears do not affect them.
- R10: `irq` is 1 exactly when some status bit and the same mask bit are both 1.
- R11: Watermark outputs, status and `irq` take their new values one clock after the push, pop or register write that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on select 0) |
| reg_addr | input | 2 | Register select: 0 data, 1 config, 2 status, 3 mask |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the current select |
| card_push | input | 1 | Card engine pushes a word |
| card_wdata | input | 16 | Word pushed by the card engine |
| card_pop | input | 1 | Card engine pops the head word |
| card_rdata | output | 16 | Current head word |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_dir | input | 1 | 1 receive, 0 transmit |
| evt_set | input | 16 | Per-bit status set pulses from other logic |
| fifo_level | output | 6 | Current occupancy, 0 to 32 |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| irq | output | 1 | Interrupt: OR of status AND mask |

## Verification
The assertions assume that the processor and the card engine never push in the same cycle, and never pop in the same cycle. The processor side has priority if they do, so a simultaneous access would break the bench's ordering model. The stimulus drives each FIFO side from one task at a time and never overlaps them. The assertions also assume that `xfer_dir` and `xfer_active` are stable around each evaluation edge. The bench changes these inputs only between accesses, at the falling edge, and samples one full clock after each access.

// File: rtl/card_fifo_pkg.sv
package card_fifo_pkg;

  localparam int REG_W  = 16;
  localparam int MARK_W = 5;
  localparam int RX_FLAG = 10;
  localparam int TX_FLAG = 11;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_BUF  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_MASK = 2'd3
  } reg_sel_e;

  // buffer configuration word; the pad fields always hold zero
  typedef struct packed {
    logic              rx_dma_en;
    logic [1:0]        pad_hi;
    logic [MARK_W-1:0] full_mark;
    logic              tx_dma_en;
    logic [1:0]        pad_lo;
    logic [MARK_W-1:0] empty_mark;
  } buf_cfg_t;

  localparam logic [REG_W-1:0] CFG_WMASK = 16'h9F9F;
  localparam logic [REG_W-1:0] CFG_RESET = 16'h1F00;

  function automatic buf_cfg_t cfg_unpack(logic [REG_W-1:0] w);
    return buf_cfg_t'(w & CFG_WMASK);
  endfunction

  function automatic logic [REG_W-1:0] cfg_pack(buf_cfg_t c);
    return REG_W'(c);
  endfunction

  function automatic logic over_mark(logic [31:0] level, logic [31:0] mark);
    return level > mark;
  endfunction

  function automatic logic under_mark(logic [31:0] level, logic [31:0] mark);
    return level < mark;
  endfunction

endpackage

// File: rtl/card_fifo_store.sv
module card_fifo_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic [CNT_W-1:0] count,
  output logic             push_ok,
  output logic             pop_ok
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0] head_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] tail;

  assign push_ok   = push && (cnt_q < CNT_W'(DEPTH));
  assign pop_ok    = pop && (cnt_q != '0);
  assign tail      = head_q + cnt_q[IDX_W-1:0];
  assign head_data = mem_q[head_q];
  assign count     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_ok) begin
      mem_q[tail] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_ok) head_q <= head_q + IDX_W'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/card_fifo_wmark.sv
module card_fifo_wmark
  import card_fifo_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  input  buf_cfg_t         cfg,
  input  logic             active,
  input  logic             dir_rx,
  output logic             rx_hit,
  output logic             tx_hit,
  output logic             rx_flag,
  output logic             tx_flag,
  output logic             rx_req,
  output logic             tx_req
);

  logic live;

  assign live    = active || (level != '0);
  assign rx_hit  = live && dir_rx  && over_mark(32'(level), 32'(cfg.full_mark));
  assign tx_hit  = live && !dir_rx && under_mark(32'(level), 32'(cfg.empty_mark));
  assign rx_flag = rx_hit && !cfg.rx_dma_en;
  assign tx_flag = tx_hit && !cfg.tx_dma_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_req <= 1'b0;
      tx_req <= 1'b0;
    end else begin
      rx_req <= rx_hit && cfg.rx_dma_en;
      tx_req <= tx_hit && cfg.tx_dma_en;
    end
  end

endmodule

// File: rtl/card_fifo_irq.sv
module card_fifo_irq
  import card_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_wr,
  input  logic             mask_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] evt_set,
  input  logic             rx_flag,
  input  logic             tx_flag,
  output logic [REG_W-1:0] stat,
  output logic [REG_W-1:0] mask,
  output logic             irq
);

  logic [REG_W-1:0] clr;
  logic [REG_W-1:0] stat_nxt;

  assign clr = stat_wr ? wdata : '0;

  always_comb begin
    stat_nxt          = (stat & ~clr) | evt_set;
    stat_nxt[RX_FLAG] = rx_flag;
    stat_nxt[TX_FLAG] = tx_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= stat_nxt;
      if (mask_wr) mask <= wdata;
    end
  end

  assign irq = |(stat & mask);

endmodule

// File: rtl/card_fifo_wm.sv
module card_fifo_wm
  import card_fifo_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             card_push,
  input  logic [WIDTH-1:0] card_wdata,
  input  logic             card_pop,
  output logic [WIDTH-1:0] card_rdata,
  input  logic             xfer_active,
  input  logic             xfer_dir,
  input  logic [REG_W-1:0] evt_set,
  output logic [CNT_W-1:0] fifo_level,
  output logic             dma_rx_req,
  output logic             dma_tx_req,
  output logic             irq
);

  reg_sel_e         sel;
  logic             cpu_push;
  logic             cpu_pop;
  logic             push;
  logic             pop;
  logic [WIDTH-1:0] push_data;
  logic [WIDTH-1:0] head_data;
  logic             push_ok;
  logic             pop_ok;
  buf_cfg_t         cfg_q;
  logic             rx_hit;
  logic             tx_hit;
  logic             rx_flag;
  logic             tx_flag;
  logic [REG_W-1:0] stat_q;
  logic [REG_W-1:0] mask_q;

  assign sel       = reg_sel_e'(reg_addr);
  assign cpu_push  = reg_wr && (sel == SEL_DATA);
  assign cpu_pop   = reg_rd && (sel == SEL_DATA);
  assign push      = cpu_push || card_push;
  assign pop       = cpu_pop || card_pop;
  assign push_data = cpu_push ? reg_wdata[WIDTH-1:0] : card_wdata;

  card_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .head_data (head_data),
    .count     (fifo_level),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= buf_cfg_t'(CFG_RESET);
    else if (reg_wr && (sel == SEL_BUF)) cfg_q <= cfg_unpack(reg_wdata);
  end

  card_fifo_wmark #(.CNT_W(CNT_W)) wmark_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (fifo_level),
    .cfg     (cfg_q),
    .active  (xfer_active),
    .dir_rx  (xfer_dir),
    .rx_hit  (rx_hit),
    .tx_hit  (tx_hit),
    .rx_flag (rx_flag),
    .tx_flag (tx_flag),
    .rx_req  (dma_rx_req),
    .tx_req  (dma_tx_req)
  );

  card_fifo_irq irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_wr (reg_wr && (sel == SEL_STAT)),
    .mask_wr (reg_wr && (sel == SEL_MASK)),
    .wdata   (reg_wdata),
    .evt_set (evt_set),
    .rx_flag (rx_flag),
    .tx_flag (tx_flag),
    .stat    (stat_q),
    .mask    (mask_q),
    .irq     (irq)
  );

  assign card_rdata = head_data;

  always_comb begin
    case (sel)
      SEL_DATA: reg_rdata = REG_W'(head_data);
      SEL_BUF:  reg_rdata = cfg_pack(cfg_q);
      SEL_STAT: reg_rdata = stat_q;
      default:  reg_rdata = mask_q;
    endcase
  end

endmodule

// File: rtl/card_fifo_wm_chk.sv
module card_fifo_wm_chk
  import card_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] evt_set,
  input logic             xfer_active,
  input logic             xfer_dir,
  input logic [CNT_W-1:0] fifo_level,
  input logic             dma_rx_req,
  input logic             dma_tx_req,
  input logic             irq,
  input buf_cfg_t         cfg_q,
  input logic [REG_W-1:0] stat_q,
  input logic [REG_W-1:0] mask_q,
  input logic             push_ok,
  input logic             pop_ok
);

  logic live;
  assign live = xfer_active || (fifo_level != '0);

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CNT_W'(DEPTH));

  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == CNT_W'(DEPTH) && !pop_ok) |=> (fifo_level == CNT_W'(DEPTH)));

  a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == '0 && !push_ok) |=> (fifo_level == '0));

  a_r5_rx_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (live && xfer_dir && fifo_level > {1'b0, cfg_q.full_mark} && cfg_q.rx_dma_en)
      |=> (dma_rx_req && !stat_q[RX_FLAG]));

  a_r5_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (live && xfer_dir && fifo_level > {1'b0, cfg_q.full_mark} && !cfg_q.rx_dma_en)
      |=> (!dma_rx_req && stat_q[RX_FLAG]));

  a_r6_tx_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !xfer_dir && fifo_level < {1'b0, cfg_q.empty_mark} && cfg_q.tx_dma_en)
      |=> (dma_tx_req && !stat_q[TX_FLAG]));

  a_r6_tx_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !xfer_dir && fifo_level < {1'b0, cfg_q.empty_mark} && !cfg_q.tx_dma_en)
      |=> (!dma_tx_req && stat_q[TX_FLAG]));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && fifo_level == '0)
      |=> (stat_q[TX_FLAG:RX_FLAG] == 2'b00 && !dma_rx_req && !dma_tx_req));

  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && evt_set == '0)
      |=> ((stat_q & $past(reg_wdata) & 16'hF3FF) == 16'h0000));

  a_r10_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

endmodule

bind card_fifo_wm card_fifo_wm_chk #(.DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .evt_set     (evt_set),
  .xfer_active (xfer_active),
  .xfer_dir    (xfer_dir),
  .fifo_level  (fifo_level),
  .dma_rx_req  (dma_rx_req),
  .dma_tx_req  (dma_tx_req),
  .irq         (irq),
  .cfg_q       (cfg_q),
  .stat_q      (stat_q),
  .mask_q      (mask_q),
  .push_ok     (push_ok),
  .pop_ok      (pop_ok)
);

// File: tb/card_fifo_wm_tb_top.sv
module card_fifo_wm_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        card_push = 1'b0;
  logic [15:0] card_wdata = '0;
  logic        card_pop = 1'b0;
  logic [15:0] card_rdata;
  logic        xfer_active = 1'b0;
  logic        xfer_dir = 1'b0;
  logic [15:0] evt_set = '0;
  logic [5:0]  fifo_level;
  logic        dma_rx_req;
  logic        dma_tx_req;
  logic        irq;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  logic [15:0] q_mem [32];
  int q_head = 0;
  int q_cnt = 0;

  always #5 clk = ~clk;

  card_fifo_wm dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
    .card_rdata(card_rdata), .xfer_active(xfer_active), .xfer_dir(xfer_dir),
    .evt_set(evt_set), .fifo_level(fifo_level), .dma_rx_req(dma_rx_req),
    .dma_tx_req(dma_tx_req), .irq(irq)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog (all): got hang, expected completion");
      summary();
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nchk = nchk + 1;
    if (got !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic m_push(logic [15:0] d);
    if (q_cnt < 32) begin
      q_mem[(q_head + q_cnt) % 32] = d;
      q_cnt = q_cnt + 1;
    end
  endtask

  task automatic m_pop(output logic [15:0] d);
    d = q_mem[q_head];
    if (q_cnt > 0) begin
      q_head = (q_head + 1) % 32;
      q_cnt = q_cnt - 1;
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic cpu_write(logic [1:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) m_push(d);
  endtask

  task automatic cpu_pop(output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = 2'd0;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic c_push(logic [15:0] d);
    card_push = 1'b1; card_wdata = d;
    @(negedge clk);
    card_push = 1'b0;
    m_push(d);
  endtask

  task automatic c_pop(output logic [15:0] d);
    card_pop = 1'b1;
    #1 d = card_rdata;
    @(negedge clk);
    card_pop = 1'b0;
  endtask

  task automatic pulse_evt(logic [15:0] e);
    evt_set = e;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic drain_cpu();
    logic [15:0] got, exp;
    while (q_cnt > 0) begin
      cpu_pop(got);
      m_pop(exp);
      check("R2 cpu pop order", 32'(got), 32'(exp));
    end
  endtask

  task automatic drain_card();
    logic [15:0] got, exp;
    while (q_cnt > 0) begin
      c_pop(got);
      m_pop(exp);
      check("R2 card pop order", 32'(got), 32'(exp));
    end
  endtask

  initial begin
    logic [15:0] v, exp;
    for (int i = 0; i < 32; i++) q_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    peek(2'd1, v); check("R1 config reset", 32'(v), 32'h1F00);
    peek(2'd2, v); check("R1 status reset", 32'(v), 32'h0);
    peek(2'd3, v); check("R1 mask reset", 32'(v), 32'h0);
    peek(2'd0, v); check("R1 data reset", 32'(v), 32'h0);
    check("R1 level reset", 32'(fifo_level), 32'd0);
    check("R1 irq reset", 32'(irq), 32'd0);
    check("R1 dma reset", {30'd0, dma_rx_req, dma_tx_req}, 32'd0);

    // R2 fill via processor, R3 overflow drop
    for (int i = 0; i < 32; i++) cpu_write(2'd0, 16'((i * 16'h0731) ^ 16'hA5C3));
    check("R2 level full", 32'(fifo_level), 32'd32);
    cpu_write(2'd0, 16'hDEAD);
    check("R3 level after drop", 32'(fifo_level), 32'd32);
    c_push(16'hBEEF);
    check("R3 level after card drop", 32'(fifo_level), 32'd32);
    drain_cpu();
    check("R2 level empty", 32'(fifo_level), 32'd0);

    // R4 underflow read returns head word, no pointer change
    cpu_pop(v);
    check("R4 empty read data", 32'(v), 32'(q_mem[q_head]));
    check("R4 empty read level", 32'(fifo_level), 32'd0);
    c_pop(v);
    check("R4 empty card pop data", 32'(v), 32'(q_mem[q_head]));
    check("R4 empty card pop level", 32'(fifo_level), 32'd0);

    // R2 wrap: offset the head then fill and drain across the wrap
    for (int i = 0; i < 20; i++) c_push(16'(16'h1000 + i));
    drain_card();
    for (int i = 0; i < 32; i++) c_push(16'(16'h5A00 ^ (i * 16'h0103)));
    check("R2 wrapped full", 32'(fifo_level), 32'd32);
    drain_cpu();

    // R5 receive watermark sweep, R11 one-clock timing
    xfer_active = 1'b1; xfer_dir = 1'b1;
    for (int en = 0; en < 2; en++) begin
      for (int af = 0; af < 32; af++) begin
        cpu_write(2'd1, {en[0], 2'b00, af[4:0], 8'h00});
        settle();
        for (int lv = 0; lv <= 32; lv++) begin
          if (lv > 0) begin
            c_push(16'(lv * 16'h0011 + af));
            settle();
          end
          peek(2'd2, v);
          check("R5 rx dma req", 32'(dma_rx_req), 32'((lv > af) && en == 1));
          check("R5 rx flag bit10", 32'(v[10]), 32'((lv > af) && en == 0));
          check("R6 tx quiet in rx", {30'd0, v[11], dma_tx_req}, 32'd0);
        end
        drain_cpu();
      end
    end

    // R6 transmit watermark sweep
    xfer_dir = 1'b0;
    for (int en = 0; en < 2; en++) begin
      for (int ae = 0; ae < 32; ae++) begin
        cpu_write(2'd1, {1'b0, 2'b00, 5'h1F, en[0], 2'b00, ae[4:0]});
        settle();
        for (int lv = 0; lv <= 32; lv++) begin
          if (lv > 0) begin
            cpu_write(2'd0, 16'(lv * 16'h0301 ^ ae));
            settle();
          end
          peek(2'd2, v);
          check("R6 tx dma req", 32'(dma_tx_req), 32'((lv < ae) && en == 1));
          check("R6 tx flag bit11", 32'(v[11]), 32'((lv < ae) && en == 0));
          check("R5 rx quiet in tx", {30'd0, v[10], dma_rx_req}, 32'd0);
        end
        drain_card();
      end
    end

    // R7 idle and empty clears flags; a non-empty FIFO stays live
    cpu_write(2'd1, 16'h1F1F);
    settle();
    peek(2'd2, v); check("R7 active empty sets bit11", 32'(v[11]), 32'd1);
    xfer_active = 1'b0;
    settle(); settle();
    peek(2'd2, v); check("R7 idle empty clears bit11", 32'(v[11]), 32'd0);
    cpu_write(2'd0, 16'h7777);
    settle();
    peek(2'd2, v); check("R7 idle nonempty still live", 32'(v[11]), 32'd1);
    drain_card();
    settle();
    peek(2'd2, v); check("R7 idle empty again", 32'(v[11]), 32'd0);
    xfer_dir = 1'b1;
    cpu_write(2'd1, 16'h8000);
    c_push(16'h4242);
    settle();
    check("R7 idle nonempty rx dma", 32'(dma_rx_req), 32'd1);
    drain_cpu();
    settle();
    check("R7 idle empty rx dma off", {30'd0, dma_rx_req, dma_tx_req}, 32'd0);
    peek(2'd2, v); check("R7 idle flags off", 32'(v[11:10]), 32'd0);

    // R8 configuration layout and enable-clears-flag
    cpu_write(2'd1, 16'hFFFF); peek(2'd1, v); check("R8 cfg all ones", 32'(v), 32'h9F9F);
    cpu_write(2'd1, 16'h6060); peek(2'd1, v); check("R8 cfg pad bits", 32'(v), 32'h0);
    cpu_write(2'd1, 16'h8A85); peek(2'd1, v); check("R8 cfg mixed", 32'(v), 32'h8A85);
    xfer_active = 1'b1; xfer_dir = 1'b0;
    cpu_write(2'd1, 16'h001F);
    settle();
    peek(2'd2, v); check("R8 flag before enable", 32'(v[11]), 32'd1);
    cpu_write(2'd1, 16'h009F);
    settle();
    peek(2'd2, v); check("R8 enable clears bit11", 32'(v[11]), 32'd0);
    check("R8 enable raises tx dma", 32'(dma_tx_req), 32'd1);
    xfer_active = 1'b0;
    cpu_write(2'd1, 16'h1F00);
    settle();

    // R9 status set and write-one-to-clear
    pulse_evt(16'hFFFF);
    peek(2'd2, v); check("R9 events set (flags excluded)", 32'(v), 32'hF3FF);
    cpu_write(2'd2, 16'h00FF); peek(2'd2, v); check("R9 partial clear", 32'(v), 32'hF300);
    cpu_write(2'd2, 16'h0000); peek(2'd2, v); check("R9 zero write keeps", 32'(v), 32'hF300);
    cpu_write(2'd2, 16'hFFFF); peek(2'd2, v); check("R9 full clear", 32'(v), 32'h0);
    pulse_evt(16'h0C00); peek(2'd2, v); check("R9 flag bits ignore events", 32'(v), 32'h0);
    evt_set = 16'h0003;
    cpu_write(2'd2, 16'h0001);
    evt_set = '0;
    peek(2'd2, v); check("R9 set beats clear", 32'(v), 32'h0003);
    cpu_write(2'd2, 16'hFFFF);

    // R10 interrupt: every status bit against every mask bit
    for (int b = 0; b < 16; b++) begin
      if (b == 10 || b == 11) continue;
      for (int m = 0; m < 16; m++) begin
        cpu_write(2'd3, 16'(1 << m));
        pulse_evt(16'(1 << b));
        check("R10 irq bit vs mask", 32'(irq), 32'(b == m));
        cpu_write(2'd2, 16'hFFFF);
        check("R10 irq after clear", 32'(irq), 32'd0);
      end
    end
    cpu_write(2'd3, 16'h0800);
    xfer_active = 1'b1; xfer_dir = 1'b0;
    cpu_write(2'd1, 16'h1F05);
    check("R11 irq not yet", 32'(irq), 32'd0);
    settle();
    check("R10 irq from tx flag", 32'(irq), 32'd1);
    cpu_write(2'd3, 16'h0000);
    check("R10 irq masked off", 32'(irq), 32'd0);

    summary();
    $finish;
  end

endmodule